// File: doc/BRIEF.md
# Self-Routing Shuffle Fabric

This block is an eight-lane switching fabric for fixed-size cells. It is built from two-by-two exchange elements placed in log2(N) columns. A perfect-shuffle wiring sits in front of every column. Each valid input cell carries a binary destination tag. Every element it crosses reads one bit of that tag and sends the cell to its upper or lower output. No central controller exists: the path of a cell is set entirely by its own tag. The block is used at the core of a cell switch. Input lanes present one cell per lane in each slot, and output lane k receives the cell whose tag equals k.

The fabric is internally blocking. Two cells with different destinations may still need the same internal link. When that happens, the cell on the element's upper input takes the link. The cell on the lower input is discarded, and a per-input blocked flag is raised for its source lane. The routing network is combinational. A single register bank at the outputs presents the delivered cells, their source index and the blocked flags one clock after the inputs.

Lanes carry a valid qualifier and have no ready signal. Cells are never held inside the fabric, so there is no back-pressure: the block accepts a fresh slot on every clock, and a sink must take every output slot as it appears. A lost cell shows up only on the blocked flags. Retrying it is the job of the logic around the block.

Top module: `selfroute_net`

## Requirements
- R1: While reset is high, and in the first slot after it, every `out_valid` bit and every `blocked` bit is 0, whatever the inputs are doing.
- R2: A cell presented before a rising clock edge appears on its output lane just after that edge and not before. In the next slot, with no new input, the lane shows `out_valid` 0 again.
- R3: A lone valid cell from any input, with any destination tag, is delivered on output lane number equal to its tag. It arrives with its payload unchanged and `out_src` equal to its input index, and no blocked flag is raised.
- R4: Column k, counting from 0 at the inputs, reads tag bit (log2 N - 1 - k), so the most significant bit is used first. A 0 selects the upper element output and a 1 the lower. The columns are joined by perfect-shuffle wiring. As a result, any cyclic-shift pattern, in which input s is sent to (s + c) mod N, delivers all N cells with no flag.
- R5: In every slot, each valid input cell is either delivered or flagged, never both, and the number of delivered cells plus raised flags equals the number of valid inputs. When all eight cells target lane 0, or all target lane 7, only the cell from input 0 is delivered and flags 0xFE are raised.
- R6: Three cells are sent: input 1 to lane 0, input 3 to lane 1 and input 4 to lane 5. Input 3 loses an internal link to input 1. The outputs then show lanes 0 and 5 valid, with sources 1 and 4, and `blocked` equal to 0x08.
- R7: Inputs i and i + N/2 meet at the same first-column element, with input i on the upper port. If both are valid and their tag MSBs are equal, input i + N/2 is flagged. If the MSBs differ, neither blocks the other.
- R8: An input whose valid bit is 0 has no effect: its tag and payload never block a valid cell and never reach an output.
- R9: A blocked flag is raised only for an input that was valid in the slot it reports. It lasts exactly one slot.
- R10: Consecutive slots are independent. The result of each slot depends only on the cells presented in that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | N_PORTS | Per-lane cell present |
| in_dest | input | N_PORTS*ADDR_W | Per-lane destination tag; lane i at bits [i*ADDR_W +: ADDR_W] |
| in_data | input | N_PORTS*DATA_W | Per-lane payload; lane i at bits [i*DATA_W +: DATA_W] |
| out_valid | output | N_PORTS | Per-output-lane cell delivered |
| out_data | output | N_PORTS*DATA_W | Delivered payload per output lane |
| out_src | output | N_PORTS*ADDR_W | Input index of the delivered cell per output lane |
| blocked | output | N_PORTS | Per-input flag: that input's cell was discarded in the previous slot |

## Verification
Lone cells over every source and destination pair prove that each input can reach each output by its tag alone, without contention. Cyclic-shift permutations load all eight lanes at once without any internal collision. This separates a correct shuffle wiring and bit order from a wrong one, because a swapped bit order or a miswired column makes those patterns collide. Contention patterns exercise the arbitration, each probing a different case. Pairs sharing a first-column element, with equal and with unequal MSBs, test the upper-input rule. The three-cell case collides in the second column. Hot spots on lanes 0 and 7 chain losses through every column. Invalid lanes with live tags, and slots driven back to back, show that nothing leaks from idle lanes or from earlier slots.

// File: rtl/selfroute_pkg.sv
package selfroute_pkg;

  // Width of one internal cell word: valid, source index, tag, payload.
  function automatic int cell_width(input int addr_w, input int data_w);
    return 1 + 2 * addr_w + data_w;
  endfunction

  // Inverse perfect shuffle: the line of the previous column that feeds
  // line n of the next column (rotate the line index right by one).
  function automatic int unshuffle(input int n, input int addr_w);
    return (n >> 1) | ((n & 1) << (addr_w - 1));
  endfunction

endpackage

// File: rtl/selfroute_elem.sv
module selfroute_elem #(
  parameter int A   = 3,
  parameter int W   = 8,
  parameter int BIT = 2
) (
  input  logic [1+2*A+W-1:0] up_i,
  input  logic [1+2*A+W-1:0] lo_i,
  output logic [1+2*A+W-1:0] up_o,
  output logic [1+2*A+W-1:0] lo_o,
  output logic               lose_o,
  output logic [A-1:0]       lose_src_o
);
  localparam int CW  = selfroute_pkg::cell_width(A, W);
  localparam int VB  = CW - 1;
  localparam int DB  = W + BIT;
  localparam int SRC = W + 2 * A - 1;

  logic u_up, u_dn, l_up, l_dn;

  always_comb begin
    u_up = up_i[VB] & ~up_i[DB];
    u_dn = up_i[VB] &  up_i[DB];
    l_up = lo_i[VB] & ~lo_i[DB];
    l_dn = lo_i[VB] &  lo_i[DB];
    // Fixed priority: the upper input always keeps the link it asks for.
    up_o = u_up ? up_i : (l_up ? lo_i : '0);
    lo_o = u_dn ? up_i : (l_dn ? lo_i : '0);
    lose_o     = (u_up & l_up) | (u_dn & l_dn);
    lose_src_o = lo_i[SRC -: A];
  end
endmodule

// File: rtl/selfroute_stage.sv
module selfroute_stage #(
  parameter int N   = 8,
  parameter int A   = 3,
  parameter int W   = 8,
  parameter int STG = 0
) (
  input  logic [1+2*A+W-1:0] cells_i [N],
  output logic [1+2*A+W-1:0] cells_o [N],
  output logic [N/2-1:0]     lose_v_o,
  output logic [A-1:0]       lose_src_o [N/2]
);
  localparam int CW  = selfroute_pkg::cell_width(A, W);
  localparam int BIT = A - 1 - STG;

  logic [CW-1:0] shuf [N];

  // Perfect-shuffle wiring in front of the column.
  for (genvar n = 0; n < N; n++) begin : g_wire
    localparam int FROM = selfroute_pkg::unshuffle(n, A);
    assign shuf[n] = cells_i[FROM];
  end

  for (genvar e = 0; e < N / 2; e++) begin : g_elem
    selfroute_elem #(.A(A), .W(W), .BIT(BIT)) u_elem (
      .up_i       (shuf[2*e]),
      .lo_i       (shuf[2*e+1]),
      .up_o       (cells_o[2*e]),
      .lo_o       (cells_o[2*e+1]),
      .lose_o     (lose_v_o[e]),
      .lose_src_o (lose_src_o[e])
    );
  end
endmodule

// File: rtl/selfroute_dropmap.sv
module selfroute_dropmap #(
  parameter int N = 8,
  parameter int A = 3
) (
  input  logic [N/2-1:0] lose_v_i   [A],
  input  logic [A-1:0]   lose_src_i [A][N/2],
  output logic [N-1:0]   blocked_o
);
  always_comb begin
    blocked_o = '0;
    for (int s = 0; s < A; s++) begin
      for (int e = 0; e < N / 2; e++) begin
        if (lose_v_i[s][e]) blocked_o[lose_src_i[s][e]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/selfroute_net.sv
module selfroute_net #(
  parameter int N_PORTS = 8,
  parameter int DATA_W  = 8
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [N_PORTS-1:0]                 in_valid,
  input  logic [N_PORTS*$clog2(N_PORTS)-1:0] in_dest,
  input  logic [N_PORTS*DATA_W-1:0]          in_data,
  output logic [N_PORTS-1:0]                 out_valid,
  output logic [N_PORTS*DATA_W-1:0]          out_data,
  output logic [N_PORTS*$clog2(N_PORTS)-1:0] out_src,
  output logic [N_PORTS-1:0]                 blocked
);
  localparam int ADDR_W = $clog2(N_PORTS);
  localparam int STAGES = ADDR_W;
  localparam int HALF   = N_PORTS / 2;
  localparam int CW     = selfroute_pkg::cell_width(ADDR_W, DATA_W);
  localparam int VB     = CW - 1;
  localparam int SRC_HI = DATA_W + 2 * ADDR_W - 1;
  localparam int DST_HI = DATA_W + ADDR_W - 1;

  logic [CW-1:0]     in_lane  [N_PORTS];
  logic [CW-1:0]     lane     [STAGES][N_PORTS];
  logic [HALF-1:0]   lose_v   [STAGES];
  logic [ADDR_W-1:0] lose_src [STAGES][HALF];
  logic [N_PORTS-1:0] blocked_c;
  logic [ADDR_W-1:0] dest_q   [N_PORTS];
  logic              live;

  always_comb begin
    for (int i = 0; i < N_PORTS; i++) begin
      in_lane[i] = {in_valid[i], ADDR_W'(i), in_dest[i*ADDR_W +: ADDR_W],
                    in_data[i*DATA_W +: DATA_W]};
    end
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_col
    if (s == 0) begin : g_first
      selfroute_stage #(.N(N_PORTS), .A(ADDR_W), .W(DATA_W), .STG(s)) u_stage (
        .cells_i    (in_lane),
        .cells_o    (lane[s]),
        .lose_v_o   (lose_v[s]),
        .lose_src_o (lose_src[s])
      );
    end else begin : g_next
      selfroute_stage #(.N(N_PORTS), .A(ADDR_W), .W(DATA_W), .STG(s)) u_stage (
        .cells_i    (lane[s-1]),
        .cells_o    (lane[s]),
        .lose_v_o   (lose_v[s]),
        .lose_src_o (lose_src[s])
      );
    end
  end

  selfroute_dropmap #(.N(N_PORTS), .A(ADDR_W)) u_dropmap (
    .lose_v_i   (lose_v),
    .lose_src_i (lose_src),
    .blocked_o  (blocked_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= '0;
      out_data  <= '0;
      out_src   <= '0;
      blocked   <= '0;
      live      <= 1'b0;
      for (int o = 0; o < N_PORTS; o++) dest_q[o] <= '0;
    end else begin
      for (int o = 0; o < N_PORTS; o++) begin
        out_valid[o]                   <= lane[STAGES-1][o][VB];
        out_data[o*DATA_W +: DATA_W]   <= lane[STAGES-1][o][DATA_W-1:0];
        out_src[o*ADDR_W +: ADDR_W]    <= lane[STAGES-1][o][SRC_HI -: ADDR_W];
        dest_q[o]                      <= lane[STAGES-1][o][DST_HI -: ADDR_W];
      end
      blocked <= blocked_c;
      live    <= 1'b1;
    end
  end

  // R1: reset leaves the outputs quiet.
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (out_valid == '0 && blocked == '0));

  // R5: every valid cell is either delivered or flagged.
  p_conserve_r5: assert property (@(posedge clk) disable iff (rst || !live)
    ($countones(out_valid) + $countones(blocked)) == $past($countones(in_valid)));

  // R3: a lone cell never collides.
  p_lone_free_r3: assert property (@(posedge clk) disable iff (rst || !live)
    ($countones(in_valid) == 1) |=> (blocked == '0 && $countones(out_valid) == 1));

  for (genvar o = 0; o < N_PORTS; o++) begin : g_chk_lane
    // R4: the path chosen by the tag bits ends on the lane named by the tag.
    p_lane_dest_r4: assert property (@(posedge clk) disable iff (rst || !live)
      out_valid[o] |-> (dest_q[o] == ADDR_W'(o)));
    // R9: a flag needs a cell on that input in the reported slot.
    p_flag_needs_cell_r9: assert property (@(posedge clk) disable iff (rst || !live)
      blocked[o] |-> $past(in_valid[o]));
  end

  for (genvar i = 0; i < HALF; i++) begin : g_chk_pair
    // R7: equal MSBs at a shared first-column element drop the lower input.
    p_upper_wins_r7: assert property (@(posedge clk) disable iff (rst || !live)
      (in_valid[i] && in_valid[i+HALF] &&
       in_dest[i*ADDR_W + ADDR_W - 1] == in_dest[(i+HALF)*ADDR_W + ADDR_W - 1])
      |=> blocked[i+HALF]);
  end
endmodule

// File: tb/selfroute_net_tb_top.sv
module selfroute_net_tb_top;
  localparam int N = 8;
  localparam int A = 3;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] in_valid;
  logic [N*A-1:0] in_dest;
  logic [N*W-1:0] in_data;
  logic [N-1:0] out_valid;
  logic [N*W-1:0] out_data;
  logic [N*A-1:0] out_src;
  logic [N-1:0] blocked;

  int  vectors = 0;
  int  miscompares = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  selfroute_net #(.N_PORTS(N), .DATA_W(W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .out_src(out_src), .blocked(blocked)
  );

  function automatic logic [W-1:0] payload(input int s, input int d);
    return W'((s * 37 + d * 11) ^ 8'h5A);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    in_valid = '0;
    in_dest  = '0;
    in_data  = '0;
  endtask

  task automatic set_cell(input int s, input int d);
    in_valid[s]       = 1'b1;
    in_dest[s*A +: A] = A'(d);
    in_data[s*W +: W] = payload(s, d);
  endtask

  task automatic expect_lane(input string tag, input int o, input int s);
    check({tag, " valid"}, 32'(out_valid[o]), 32'd1);
    check({tag, " src"}, 32'(out_src[o*A +: A]), 32'(s));
    check({tag, " data"}, 32'(out_data[o*W +: W]), 32'(payload(s, o)));
  endtask

  task automatic slot();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    clear_in();
    set_cell(2, 6);
    repeat (3) slot();
    check("R1 out_valid in reset", 32'(out_valid), 32'h0);
    check("R1 blocked in reset", 32'(blocked), 32'h0);
    clear_in();
    rst = 1'b0;
    slot();
    check("R1 out_valid after reset", 32'(out_valid), 32'h0);
    check("R1 blocked after reset", 32'(blocked), 32'h0);
  endtask

  task automatic t_latency();
    clear_in();
    set_cell(5, 2);
    #1;
    check("R2 not before edge", 32'(out_valid), 32'h0);
    slot();
    expect_lane("R2 after edge", 2, 5);
    clear_in();
    slot();
    check("R2 gone next slot", 32'(out_valid), 32'h0);
  endtask

  task automatic t_lone();
    for (int s = 0; s < N; s++) begin
      for (int d = 0; d < N; d++) begin
        clear_in();
        set_cell(s, d);
        slot();
        check("R3 lone mask", 32'(out_valid), 32'(1 << d));
        expect_lane("R3 lone", d, s);
        check("R3 lone blocked", 32'(blocked), 32'h0);
      end
    end
  endtask

  task automatic t_shift();
    for (int c = 0; c < N; c++) begin
      clear_in();
      for (int s = 0; s < N; s++) set_cell(s, (s + c) % N);
      slot();
      check("R4 shift mask", 32'(out_valid), 32'hFF);
      check("R4 shift blocked", 32'(blocked), 32'h0);
      for (int o = 0; o < N; o++) expect_lane("R4 shift lane", o, (o - c + N) % N);
    end
  endtask

  task automatic t_three_cells();
    clear_in();
    set_cell(1, 0);
    set_cell(3, 1);
    set_cell(4, 5);
    slot();
    check("R6 mask", 32'(out_valid), 32'h21);
    expect_lane("R6 lane0", 0, 1);
    expect_lane("R6 lane5", 5, 4);
    check("R6 blocked", 32'(blocked), 32'h08);
  endtask

  task automatic t_pairs();
    clear_in();
    set_cell(0, 0);
    set_cell(4, 0);
    slot();
    check("R7 pair0 mask", 32'(out_valid), 32'h01);
    expect_lane("R7 pair0", 0, 0);
    check("R7 pair0 blocked", 32'(blocked), 32'h10);
    clear_in();
    set_cell(1, 6);
    set_cell(5, 4);
    slot();
    check("R7 pair1 mask", 32'(out_valid), 32'h40);
    expect_lane("R7 pair1", 6, 1);
    check("R7 pair1 blocked", 32'(blocked), 32'h20);
    clear_in();
    set_cell(2, 3);
    set_cell(6, 7);
    slot();
    check("R7 split mask", 32'(out_valid), 32'h88);
    expect_lane("R7 split lane3", 3, 2);
    expect_lane("R7 split lane7", 7, 6);
    check("R7 split blocked", 32'(blocked), 32'h0);
  endtask

  task automatic t_hotspot();
    for (int h = 0; h < 2; h++) begin
      clear_in();
      for (int s = 0; s < N; s++) set_cell(s, h * 7);
      slot();
      check("R5 hotspot mask", 32'(out_valid), 32'(1 << (h * 7)));
      expect_lane("R5 hotspot", h * 7, 0);
      check("R5 hotspot blocked", 32'(blocked), 32'hFE);
    end
  endtask

  task automatic t_ignore();
    clear_in();
    set_cell(3, 1);
    in_dest[1*A +: A] = 3'd0;
    in_data[1*W +: W] = 8'hEE;
    in_dest[7*A +: A] = 3'd1;
    in_data[7*W +: W] = 8'h77;
    slot();
    check("R8 mask", 32'(out_valid), 32'h02);
    expect_lane("R8 survivor", 1, 3);
    check("R8 blocked", 32'(blocked), 32'h0);
    clear_in();
    for (int s = 0; s < N; s++) in_dest[s*A +: A] = 3'd4;
    in_data = '1;
    slot();
    check("R8 all idle mask", 32'(out_valid), 32'h0);
    check("R8 all idle blocked", 32'(blocked), 32'h0);
  endtask

  task automatic t_stream();
    clear_in();
    for (int s = 0; s < N; s++) set_cell(s, 0);
    slot();
    check("R10 slotA blocked", 32'(blocked), 32'hFE);
    clear_in();
    for (int s = 0; s < N; s++) set_cell(s, (s + 3) % N);
    slot();
    check("R9 flags cleared", 32'(blocked), 32'h0);
    check("R10 slotB mask", 32'(out_valid), 32'hFF);
    expect_lane("R10 slotB lane0", 0, 5);
    clear_in();
    set_cell(6, 6);
    slot();
    check("R10 slotC mask", 32'(out_valid), 32'h40);
    expect_lane("R10 slotC", 6, 6);
    clear_in();
    slot();
    check("R10 idle mask", 32'(out_valid), 32'h0);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_lone();
    t_shift();
    t_three_cells();
    t_pairs();
    t_hotspot();
    t_ignore();
    t_stream();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule